// File: doc/BRIEF.md
# Clock Source Mode Controller

This block is the control half of a clock generator that can draw its output clock from three places: a locked loop (frequency-locked or phase-locked), an internal reference oscillator, or an external reference. Software-style request inputs ask for a loop reference, an output source, a loop type and a low-power bypass. Ready flags stand in for the analog oscillators and for loop lock. From these the block drives the loop enables and the reference output enables, steers the output clock multiplexer, reports which source and reference are in use, and produces a bus clock enable from a 2-bit divider code.

Requests may change at any moment. The status fields follow a request only when the target is confirmed ready, so software can poll them to learn when a switch is done. A request for a source that is not ready leaves the current one in place. A debug session overrides the low-power bypass so that a loop clock is running. Stop mode freezes every selection and keeps a reference running only when it is both enabled and enabled for stop.

Top module: `clksrc_mode_ctrl`

## Requirements
- R1: After reset, src_stat and clk_mux_sel are 01 (internal reference), ref_stat is 0, lp_bypass and loop_relock are 0, and with pll_sel at 0 fll_en is 1 and pll_en is 0.
- R2: Source codes are 00 locked loop, 01 internal reference, 10 external reference. Ready inputs pass through two flip-flops. A new source code appears on src_stat and clk_mux_sel on the third rising edge after its ready input rises, or on the first edge after the request when that ready is already synchronised. The status only ever changes to the requested code.
- R3: While the requested source is not ready, src_stat keeps the previous source.
- R4: A request of 11 is reserved and is ignored: src_stat holds.
- R5: With lowpwr at 1, src_stat at 10 and dbg_active at 0, lp_bypass is 1 from the next edge. While lp_bypass is 1, fll_en and pll_en are 0 and a request for the loop source (00) is not honoured.
- R6: dbg_active at 1 clears lp_bypass on the next edge. The loop then runs as a PLL (pll_en) when pll_sel is 1 and as an FLL (fll_en) when pll_sel is 0.
- R7: ref_sel_req selects the loop reference (0 internal, 1 external). ref_stat takes the requested value one edge after that reference's synchronised ready is 1, and loop_relock is set on the same edge.
- R8: While loop_relock is 1 the loop source cannot be selected. loop_relock clears on the edge after the synchronised loop ready is seen low. After that, the loop can be selected once its ready is high again.
- R9: In stop (stop_in at 1) fll_en, pll_en and bus_ce are 0 and neither src_stat nor ref_stat changes. Pending requests complete after stop ends.
- R10: intref_active is intref_en outside stop and intref_en AND intref_stop_en in stop. extref_active follows the same rule with the external enables.
- R11: bus_div code n (0..3) gives one bus_ce pulse every 2^n cycles. A new code acts on bus_ce in the same cycle, with no status handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_sel_req | input | 1 | Requested loop reference: 0 internal, 1 external |
| src_sel_req | input | 2 | Requested output source code |
| pll_sel | input | 1 | Loop type: 1 PLL, 0 FLL |
| lowpwr | input | 1 | Low-power bypass request |
| stop_in | input | 1 | Stop mode |
| dbg_active | input | 1 | Debug session active |
| intref_en | input | 1 | Internal reference output enable |
| intref_stop_en | input | 1 | Keep internal reference in stop |
| extref_en | input | 1 | External reference output enable |
| extref_stop_en | input | 1 | Keep external reference in stop |
| intref_ready | input | 1 | Internal reference ready (asynchronous) |
| extref_ready | input | 1 | External reference ready (asynchronous) |
| loop_ready | input | 1 | Loop locked (asynchronous) |
| bus_div | input | 2 | Bus divide code, divide by 2^code |
| fll_en | output | 1 | FLL enable |
| pll_en | output | 1 | PLL enable |
| intref_active | output | 1 | Internal reference output running |
| extref_active | output | 1 | External reference output running |
| src_stat | output | 2 | Source in use |
| ref_stat | output | 1 | Loop reference in use |
| clk_mux_sel | output | 2 | Output clock multiplexer select |
| lp_bypass | output | 1 | Low-power bypass mode active |
| loop_relock | output | 1 | Loop restarting lock after reference switch |
| bus_ce | output | 1 | Bus clock enable pulse |

## Verification
The hardest state to reach is a loop source request blocked by a pending relock. Reaching it takes a committed loop source, then a reference switch, then a drop and return of loop lock, with the synchroniser latency counted at each step. The bench walks there in order: it first commits the loop, then switches the reference, moves away to the internal source, and shows that the loop request is refused until loop_ready has been taken low and raised again. It also counts the exact edges of each transition.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int SRC_W   = 2;
  localparam int NCODES  = 1 << SRC_W;
  localparam int DIV_W   = 2;
  localparam int CNT_W   = (1 << DIV_W) - 1;

  typedef enum logic [SRC_W-1:0] {
    SRC_LOOP = 2'b00,
    SRC_INT  = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;

  // mask of counter bits that must all be ones for a bus enable pulse
  function automatic logic [CNT_W-1:0] div_mask(input logic [DIV_W-1:0] code);
    logic [CNT_W-1:0] m;
    m = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(code)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic src_valid(input src_e s);
    return s != SRC_RSVD;
  endfunction
endpackage

// File: rtl/clksrc_sync.sv
module clksrc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/clksrc_select.sv
module clksrc_select
  import clksrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  input  src_e              src_req,
  input  logic              ref_req,
  input  logic              lowpwr,
  input  logic              dbg_active,
  input  logic              loop_on,
  input  logic [NCODES-2:0] rdy_s,
  output src_e              src_stat,
  output logic              ref_stat,
  output logic              relock_pend,
  output logic              lp_bypass,
  output logic              src_commit,
  output logic              ref_commit
);
  logic [NCODES-1:0] avail;
  logic              ref_rdy;
  logic              lp_next;

  // availability per source code; the reserved code is never available
  always_comb begin
    avail           = '0;
    avail[SRC_LOOP] = rdy_s[SRC_LOOP] & loop_on & ~relock_pend;
    avail[SRC_INT]  = rdy_s[SRC_INT];
    avail[SRC_EXT]  = rdy_s[SRC_EXT];
  end

  assign ref_rdy    = ref_req ? rdy_s[SRC_EXT] : rdy_s[SRC_INT];
  assign src_commit = ~stop & src_valid(src_req) & (src_req != src_stat) & avail[src_req];
  assign ref_commit = ~stop & (ref_req != ref_stat) & ref_rdy;
  assign lp_next    = lowpwr & (src_stat == SRC_EXT) & ~dbg_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_stat    <= SRC_INT;
      ref_stat    <= 1'b0;
      relock_pend <= 1'b0;
      lp_bypass   <= 1'b0;
    end else begin
      if (src_commit) src_stat <= src_req;
      if (ref_commit) ref_stat <= ref_req;
      if (ref_commit)             relock_pend <= 1'b1;
      else if (!rdy_s[SRC_LOOP])  relock_pend <= 1'b0;
      lp_bypass <= lp_next;
    end
  end
endmodule

// File: rtl/clksrc_enables.sv
module clksrc_enables (
  input  logic lp_bypass,
  input  logic stop,
  input  logic pll_sel,
  input  logic intref_en,
  input  logic intref_stop_en,
  input  logic extref_en,
  input  logic extref_stop_en,
  output logic fll_en,
  output logic pll_en,
  output logic intref_active,
  output logic extref_active,
  output logic loop_on
);
  logic loop_allowed;

  assign loop_allowed  = ~stop & ~lp_bypass;
  assign fll_en        = loop_allowed & ~pll_sel;
  assign pll_en        = loop_allowed &  pll_sel;
  assign loop_on       = loop_allowed;
  assign intref_active = intref_en & (~stop | intref_stop_en);
  assign extref_active = extref_en & (~stop | extref_stop_en);
endmodule

// File: rtl/clksrc_busdiv.sv
module clksrc_busdiv
  import clksrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic [DIV_W-1:0] div_code,
  output logic             ce
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign mask = div_mask(div_code);
  assign ce   = ~stop & ((cnt & mask) == mask);
endmodule

// File: rtl/clksrc_mode_ctrl.sv
module clksrc_mode_ctrl
  import clksrc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_sel_req,
  input  logic [1:0]       src_sel_req,
  input  logic             pll_sel,
  input  logic             lowpwr,
  input  logic             stop_in,
  input  logic             dbg_active,
  input  logic             intref_en,
  input  logic             intref_stop_en,
  input  logic             extref_en,
  input  logic             extref_stop_en,
  input  logic             intref_ready,
  input  logic             extref_ready,
  input  logic             loop_ready,
  input  logic [1:0]       bus_div,
  output logic             fll_en,
  output logic             pll_en,
  output logic             intref_active,
  output logic             extref_active,
  output logic [1:0]       src_stat,
  output logic             ref_stat,
  output logic [1:0]       clk_mux_sel,
  output logic             lp_bypass,
  output logic             loop_relock,
  output logic             bus_ce
);
  logic [NCODES-2:0] rdy_raw;
  logic [NCODES-2:0] rdy_s;
  logic              loop_on;
  logic              src_commit;
  logic              ref_commit;
  src_e              src_state;

  always_comb begin
    rdy_raw           = '0;
    rdy_raw[SRC_LOOP] = loop_ready;
    rdy_raw[SRC_INT]  = intref_ready;
    rdy_raw[SRC_EXT]  = extref_ready;
  end

  clksrc_sync #(.WIDTH(NCODES-1), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rdy_raw),
    .q     (rdy_s)
  );

  clksrc_select u_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop        (stop_in),
    .src_req     (src_e'(src_sel_req)),
    .ref_req     (ref_sel_req),
    .lowpwr      (lowpwr),
    .dbg_active  (dbg_active),
    .loop_on     (loop_on),
    .rdy_s       (rdy_s),
    .src_stat    (src_state),
    .ref_stat    (ref_stat),
    .relock_pend (loop_relock),
    .lp_bypass   (lp_bypass),
    .src_commit  (src_commit),
    .ref_commit  (ref_commit)
  );

  clksrc_enables u_enables (
    .lp_bypass      (lp_bypass),
    .stop           (stop_in),
    .pll_sel        (pll_sel),
    .intref_en      (intref_en),
    .intref_stop_en (intref_stop_en),
    .extref_en      (extref_en),
    .extref_stop_en (extref_stop_en),
    .fll_en         (fll_en),
    .pll_en         (pll_en),
    .intref_active  (intref_active),
    .extref_active  (extref_active),
    .loop_on        (loop_on)
  );

  clksrc_busdiv u_busdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop     (stop_in),
    .div_code (bus_div),
    .ce       (bus_ce)
  );

  assign src_stat    = src_state;
  assign clk_mux_sel = src_state;
endmodule

// File: rtl/clksrc_mode_ctrl_chk.sv
module clksrc_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_sel_req,
  input logic [1:0] src_sel_req,
  input logic       pll_sel,
  input logic       stop_in,
  input logic       dbg_active,
  input logic       intref_en,
  input logic       intref_stop_en,
  input logic       extref_en,
  input logic       extref_stop_en,
  input logic [1:0] bus_div,
  input logic       fll_en,
  input logic       pll_en,
  input logic       intref_active,
  input logic       extref_active,
  input logic [1:0] src_stat,
  input logic       ref_stat,
  input logic       lp_bypass,
  input logic       loop_relock,
  input logic       bus_ce,
  input logic       src_commit,
  input logic       ref_commit
);
  // R2: status only ever moves to the code that was requested
  assert_src_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_stat != $past(src_stat)) |-> (src_stat == $past(src_sel_req)));

  // R4: reserved request leaves the status alone
  assert_rsvd_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_req == 2'b11) |=> $stable(src_stat));

  // R5: both loops stopped in low-power bypass
  assert_lp_loops_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lp_bypass |-> (!fll_en && !pll_en));

  // R6: debug leaves low-power bypass on the next edge
  assert_dbg_exits_lp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active |=> !lp_bypass);

  // R7: a reference switch starts a relock
  assert_ref_switch_relock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stat != $past(ref_stat)) |-> loop_relock);

  // R8: loop source never committed while relocking
  assert_no_loop_in_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_commit && src_sel_req == 2'b00) |-> !loop_relock);

  // R9: stop turns loops and bus enable off and freezes status
  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_in |-> (!fll_en && !pll_en && !bus_ce && !src_commit && !ref_commit));
  assert_stop_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_in) |-> ($stable(src_stat) && $stable(ref_stat)));

  // R10: a reference runs in stop only with both enables
  assert_intref_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_in && !(intref_en && intref_stop_en)) |-> !intref_active);
  assert_extref_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_in && !(extref_en && extref_stop_en)) |-> !extref_active);

  // R11: divide-by-one pulses every cycle outside stop
  assert_div1_every_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_div == 2'd0 && !stop_in) |-> bus_ce);

  // R6: loop type follows pll_sel whenever the loop runs
  assert_loop_type_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fll_en || pll_en) |-> (pll_en == pll_sel));
endmodule

bind clksrc_mode_ctrl clksrc_mode_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ref_sel_req    (ref_sel_req),
  .src_sel_req    (src_sel_req),
  .pll_sel        (pll_sel),
  .stop_in        (stop_in),
  .dbg_active     (dbg_active),
  .intref_en      (intref_en),
  .intref_stop_en (intref_stop_en),
  .extref_en      (extref_en),
  .extref_stop_en (extref_stop_en),
  .bus_div        (bus_div),
  .fll_en         (fll_en),
  .pll_en         (pll_en),
  .intref_active  (intref_active),
  .extref_active  (extref_active),
  .src_stat       (src_stat),
  .ref_stat       (ref_stat),
  .lp_bypass      (lp_bypass),
  .loop_relock    (loop_relock),
  .bus_ce         (bus_ce),
  .src_commit     (src_commit),
  .ref_commit     (ref_commit)
);

// File: tb/clksrc_mode_ctrl_tb.sv
module clksrc_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_sel_req = 1'b0;
  logic [1:0] src_sel_req = 2'b01;
  logic       pll_sel = 1'b0;
  logic       lowpwr = 1'b0;
  logic       stop_in = 1'b0;
  logic       dbg_active = 1'b0;
  logic       intref_en = 1'b1;
  logic       intref_stop_en = 1'b0;
  logic       extref_en = 1'b1;
  logic       extref_stop_en = 1'b1;
  logic       intref_ready = 1'b1;
  logic       extref_ready = 1'b0;
  logic       loop_ready = 1'b0;
  logic [1:0] bus_div = 2'd0;
  logic       fll_en, pll_en, intref_active, extref_active;
  logic [1:0] src_stat, clk_mux_sel;
  logic       ref_stat, lp_bypass, loop_relock, bus_ce;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  clksrc_mode_ctrl u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check(src_stat == 2'b01, "R1 src_stat", src_stat, 1);
    check(clk_mux_sel == 2'b01, "R1 mux", clk_mux_sel, 1);
    check(ref_stat == 1'b0, "R1 ref_stat", ref_stat, 0);
    check(!lp_bypass && !loop_relock, "R1 modes", {lp_bypass, loop_relock}, 0);
    check(fll_en && !pll_en, "R1 loop enables", {fll_en, pll_en}, 2);
  endtask

  task automatic t_switch_ext;
    src_sel_req = 2'b10;
    step(4);
    check(src_stat == 2'b01, "R3 unready held", src_stat, 1);
    extref_ready = 1'b1;
    step(2);
    check(src_stat == 2'b01, "R2 before sync done", src_stat, 1);
    step(1);
    check(src_stat == 2'b10, "R2 third edge", src_stat, 2);
    check(clk_mux_sel == 2'b10, "R2 mux", clk_mux_sel, 2);
  endtask

  task automatic t_reserved;
    src_sel_req = 2'b11;
    step(4);
    check(src_stat == 2'b10, "R4 reserved ignored", src_stat, 2);
    src_sel_req = 2'b10;
  endtask

  task automatic t_lowpwr_debug;
    lowpwr = 1'b1;
    step(1);
    check(lp_bypass, "R5 enter bypass", lp_bypass, 1);
    check(!fll_en && !pll_en, "R5 loops off", {fll_en, pll_en}, 0);
    pll_sel = 1'b1;
    dbg_active = 1'b1;
    step(1);
    check(!lp_bypass && pll_en && !fll_en, "R6 debug to pll", {lp_bypass, pll_en, fll_en}, 2);
    dbg_active = 1'b0;
    step(1);
    check(lp_bypass, "R6 back to bypass", lp_bypass, 1);
    pll_sel = 1'b0;
    dbg_active = 1'b1;
    step(1);
    check(!lp_bypass && fll_en && !pll_en, "R6 debug to fll", {lp_bypass, pll_en, fll_en}, 1);
    dbg_active = 1'b0;
    step(1);
  endtask

  task automatic t_loop_in_bypass;
    loop_ready = 1'b1;
    src_sel_req = 2'b00;
    step(5);
    check(src_stat == 2'b10, "R5 loop refused in bypass", src_stat, 2);
    lowpwr = 1'b0;
    step(1);
    check(src_stat == 2'b10 && !lp_bypass, "R5 bypass left", src_stat, 2);
    step(1);
    check(src_stat == 2'b00, "R2 loop selected", src_stat, 0);
  endtask

  task automatic t_ref_switch;
    ref_sel_req = 1'b1;
    step(1);
    check(ref_stat == 1'b1, "R7 ref_stat", ref_stat, 1);
    check(loop_relock, "R7 relock set", loop_relock, 1);
    check(src_stat == 2'b00, "R3 loop kept", src_stat, 0);
    src_sel_req = 2'b01;
    step(1);
    check(src_stat == 2'b01, "R2 int immediate", src_stat, 1);
    src_sel_req = 2'b00;
    step(4);
    check(src_stat == 2'b01, "R8 loop refused in relock", src_stat, 1);
    loop_ready = 1'b0;
    step(4);
    check(!loop_relock, "R8 relock cleared", loop_relock, 0);
    loop_ready = 1'b1;
    step(2);
    check(src_stat == 2'b01, "R8 waits for lock", src_stat, 1);
    step(1);
    check(src_stat == 2'b00, "R8 loop after relock", src_stat, 0);
  endtask

  task automatic t_stop;
    int ce_cnt;
    stop_in = 1'b1;
    src_sel_req = 2'b10;
    #1;
    check(!fll_en && !pll_en, "R9 loops off", {fll_en, pll_en}, 0);
    check(!intref_active, "R10 int off in stop", intref_active, 0);
    check(extref_active, "R10 ext kept in stop", extref_active, 1);
    intref_stop_en = 1'b1;
    #1;
    check(intref_active, "R10 int kept with stop enable", intref_active, 1);
    extref_en = 1'b0;
    #1;
    check(!extref_active, "R10 ext off without enable", extref_active, 0);
    ce_cnt = 0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      if (bus_ce) ce_cnt++;
    end
    check(ce_cnt == 0, "R9 bus_ce held", ce_cnt, 0);
    check(src_stat == 2'b00, "R9 status frozen", src_stat, 0);
    stop_in = 1'b0;
    extref_en = 1'b1;
    #1;
    check(intref_active && extref_active, "R10 outside stop", {intref_active, extref_active}, 3);
    step(1);
    check(src_stat == 2'b10, "R9 commit after stop", src_stat, 2);
  endtask

  task automatic t_busdiv;
    int ce_cnt;
    for (int code = 0; code < 4; code++) begin
      bus_div = 2'(code);
      ce_cnt = 0;
      for (int i = 0; i < 16; i++) begin
        #1;
        if (bus_ce) ce_cnt++;
        step(1);
      end
      check(ce_cnt == (16 >> code), "R11 divide rate", ce_cnt, 16 >> code);
    end
    bus_div = 2'd0;
    #1;
    check(bus_ce, "R11 immediate change", bus_ce, 1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_switch_ext();
    t_reserved();
    t_lowpwr_debug();
    t_loop_in_bypass();
    t_ref_switch();
    t_stop();
    t_busdiv();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule